// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit descriptors held in host memory. A poll-demand pulse starts it at the current-descriptor pointer. It fetches each 32-byte descriptor as eight consecutive 32-bit reads and stops as soon as the first word shows that software does not own the entry.

For an owned descriptor, it reads the buffer data a word at a time from the buffer-1 address and emits it one byte at a time on a valid/ready byte stream. The final byte of a frame carries a last flag. The block then writes the first descriptor word back with the ownership flag cleared. The pointer either steps to the next descriptor or returns to the list base. The walk then repeats until an unowned entry is found.

A one-cycle completion pulse follows the writeback of every frame-ending descriptor. A one-cycle error pulse flags buffer sizes outside the supported range, and the data is transferred regardless. MAC framing, CRC and the register bank belong to other blocks; the list base is loaded through a plain write strobe.

Top module: `txring_walker`

## Requirements
- R1: After reset the block is idle (`idle_o`=1), issues no memory request, presents no stream byte, holds `cur_ptr_o`=0 and keeps `done_o` and `err_o` low.
- R2: A `poll_i` pulse while idle starts a walk whose first read is word 0 of the descriptor at `cur_ptr_o`.
- R3: If bit 31 (ownership) of a fetched word 0 is clear, the walk ends: no further read, no stream byte, no writeback, the pointer is unchanged and the block returns to idle.
- R4: A descriptor is read as eight words at pointer+0, +4 … +28. Word 1 holds the buffer-1 size in bits 15:0 and the buffer-2 size in bits 31:16. Word 2 holds the buffer-1 address.
- R5: The byte count is bits 11:0 of the buffer-1 size plus bits 11:0 of the buffer-2 size. The bytes are streamed in ascending address order starting at the buffer-1 address, which may have any alignment. Byte k of a word sits in bits 8k+7:8k.
- R6: `tx_last_o` is high on the final streamed byte of a descriptor whose bit 29 (last segment) is set, and is low on every other byte.
- R7: After the data, word 0 is written back to the pointer address with bit 31 cleared and all other bits unchanged. Words 1–7 are not written.
- R8: After the writeback, the pointer reloads from the list base if bit 21 (end of ring) of word 0 is set, and otherwise advances by 32.
- R9: `done_o` pulses for exactly one cycle after the writeback of each descriptor with bit 29 set, and never for other descriptors.
- R10: `err_o` pulses once for a descriptor whose masked buffer-1 size exceeds 2048 or whose masked buffer-2 size is nonzero. The descriptor's bytes are still streamed in full.
- R11: `base_wr_i` loads `base_i` into both the list base and `cur_ptr_o`.
- R12: A memory request holds its address, direction and write data until `mem_ready_i`. A stream byte holds its data and last flag until `tx_ready_i`.
- R13: A descriptor with a byte count of zero streams nothing but is still written back, moves the pointer and, with bit 29 set, still pulses `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_i | input | 1 | Poll demand, starts a walk when idle |
| base_wr_i | input | 1 | Load strobe for the list base |
| base_i | input | 32 | List base value |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_ready_i | input | 1 | Stream sink accepts the byte |
| done_o | output | 1 | Frame completion pulse |
| err_o | output | 1 | Buffer size error pulse |
| idle_o | output | 1 | Walker idle |
| cur_ptr_o | output | 32 | Current descriptor pointer |

## Verification
The assertions assume that the memory returns exactly one `mem_rvalid_i` for each accepted read, strictly after the acceptance cycle and before any other request is issued. They also assume that `base_wr_i` is pulsed only while the block is idle. The bench's memory model answers every accepted read on the following cycle and loads the base only between walks. It throttles both `mem_ready_i` and `tx_ready_i` with fixed periodic patterns, so that the holding rules are exercised without breaking these assumptions.

// File: rtl/txw_pkg.sv
package txw_pkg;
   typedef enum logic [2:0] {
      W_IDLE, W_FETCH, W_FWAIT, W_DECODE, W_DREQ, W_DWAIT, W_STREAM, W_WBACK
   } walk_state_t;
endpackage

// File: rtl/txw_ptr_reg.sv
module txw_ptr_reg #(
   parameter int AW   = 32,
   parameter int STEP = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_wr_i,
   input  logic [AW-1:0] base_i,
   input  logic          adv_i,
   input  logic          wrap_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);
   logic [AW-1:0] base_q, ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ptr_q  <= '0;
      end else if (base_wr_i) begin
         base_q <= base_i;
         ptr_q  <= base_i;
      end else if (adv_i) begin
         ptr_q  <= wrap_i ? base_q : ptr_q + STEP_V;
      end
   end
   assign ptr_o = ptr_q;

   assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !wrap_i && !base_wr_i) |=> ptr_q == $past(ptr_q) + STEP_V);
   assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && wrap_i && !base_wr_i) |=> ptr_q == $past(base_q));
   assert_base_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr_i |=> ptr_q == $past(base_i));
endmodule

// File: rtl/txw_desc_decode.sv
module txw_desc_decode #(
   parameter int SIZE_BITS   = 12,
   parameter int MAX_BUF1    = 2048,
   parameter bit CHECK_SIZES = 1'b1
) (
   input  logic [SIZE_BITS-1:0] b1_size_i,
   input  logic [SIZE_BITS-1:0] b2_size_i,
   output logic [SIZE_BITS:0]   len_o,
   output logic                 err_o
);
   assign len_o = {1'b0, b1_size_i} + {1'b0, b2_size_i};

   generate
      if (CHECK_SIZES) begin : g_chk
         assign err_o = (b1_size_i > SIZE_BITS'(MAX_BUF1)) || (b2_size_i != '0);
      end else begin : g_nochk
         assign err_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/txw_lane_sel.sv
module txw_lane_sel #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0]         word_i,
   input  logic [$clog2(LANES)-1:0]   sel_i,
   output logic [7:0]                 byte_o
);
   logic [7:0] lanes [LANES];
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = word_i[8*g +: 8];
      end
   endgenerate
   assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
   parameter int AW          = 32,
   parameter int DESC_BYTES  = 32,
   parameter int SIZE_BITS   = 12,
   parameter int MAX_BUF1    = 2048,
   parameter int OWN_BIT     = 31,
   parameter int LAST_BIT    = 29,
   parameter int WRAP_BIT    = 21,
   parameter bit CHECK_SIZES = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          poll_i,
   input  logic          base_wr_i,
   input  logic [AW-1:0] base_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [31:0]   mem_wdata_o,
   input  logic          mem_ready_i,
   input  logic          mem_rvalid_i,
   input  logic [31:0]   mem_rdata_i,
   output logic          tx_valid_o,
   output logic [7:0]    tx_data_o,
   output logic          tx_last_o,
   input  logic          tx_ready_i,
   output logic          done_o,
   output logic          err_o,
   output logic          idle_o,
   output logic [AW-1:0] cur_ptr_o
);
   import txw_pkg::*;

   localparam int WORD_BYTES = 4;
   localparam int DESC_WORDS = DESC_BYTES / WORD_BYTES;
   localparam int WIDX_W     = $clog2(DESC_WORDS);
   localparam int CNT_W      = SIZE_BITS + 1;
   localparam logic [WIDX_W-1:0] WIDX_END = WIDX_W'(DESC_WORDS - 1);
   localparam logic [31:0] OWN_MASK = 32'h1 << OWN_BIT;

   generate
      if (DESC_BYTES % WORD_BYTES != 0 || DESC_BYTES < 12) begin : g_bad_desc
         $error("descriptor must be whole words and hold at least three");
      end
      if (MAX_BUF1 >= (1 << SIZE_BITS)) begin : g_bad_max
         $error("buffer-1 limit must fit the size field");
      end
      if (OWN_BIT > 31 || LAST_BIT > 31 || WRAP_BIT > 31) begin : g_bad_bit
         $error("flag positions must lie in a 32-bit word");
      end
   endgenerate

   walk_state_t          state_q;
   logic [WIDX_W-1:0]    widx_q;
   logic [31:0]          cs_q;
   logic [SIZE_BITS-1:0] b1_q, b2_q;
   logic [AW-1:0]        bptr_q;
   logic [CNT_W-1:0]     rem_q;
   logic [31:0]          word_q;
   logic                 done_q, err_q;

   logic [CNT_W-1:0]     dec_len;
   logic                 dec_err;
   logic                 acc, adv, last_byte;

   txw_desc_decode #(.SIZE_BITS(SIZE_BITS), .MAX_BUF1(MAX_BUF1), .CHECK_SIZES(CHECK_SIZES))
   u_dec (.b1_size_i(b1_q), .b2_size_i(b2_q), .len_o(dec_len), .err_o(dec_err));

   txw_ptr_reg #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .base_wr_i(base_wr_i), .base_i(base_i),
      .adv_i(adv), .wrap_i(cs_q[WRAP_BIT]), .ptr_o(cur_ptr_o));

   txw_lane_sel #(.LANES(WORD_BYTES)) u_lane (
      .word_i(word_q), .sel_i(bptr_q[1:0]), .byte_o(tx_data_o));

   assign acc       = mem_req_o && mem_ready_i;
   assign adv       = (state_q == W_WBACK) && mem_ready_i;
   assign mem_req_o = (state_q == W_FETCH) || (state_q == W_DREQ) || (state_q == W_WBACK);
   assign mem_we_o  = (state_q == W_WBACK);
   assign mem_wdata_o = cs_q & ~OWN_MASK;
   assign last_byte = (rem_q == CNT_W'(1));

   always_comb begin
      case (state_q)
         W_FETCH: mem_addr_o = cur_ptr_o + AW'({widx_q, 2'b00});
         W_DREQ:  mem_addr_o = {bptr_q[AW-1:2], 2'b00};
         default: mem_addr_o = cur_ptr_o;
      endcase
   end

   assign tx_valid_o = (state_q == W_STREAM);
   assign tx_last_o  = tx_valid_o && cs_q[LAST_BIT] && last_byte;
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign idle_o     = (state_q == W_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= W_IDLE;
         widx_q  <= '0;
         cs_q    <= '0;
         b1_q    <= '0;
         b2_q    <= '0;
         bptr_q  <= '0;
         rem_q   <= '0;
         word_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            W_IDLE: if (poll_i) begin
               widx_q  <= '0;
               state_q <= W_FETCH;
            end
            W_FETCH: if (acc) state_q <= W_FWAIT;
            W_FWAIT: if (mem_rvalid_i) begin
               case (widx_q)
                  WIDX_W'(0): cs_q   <= mem_rdata_i;
                  WIDX_W'(1): begin
                     b1_q <= mem_rdata_i[SIZE_BITS-1:0];
                     b2_q <= mem_rdata_i[16 +: SIZE_BITS];
                  end
                  WIDX_W'(2): bptr_q <= mem_rdata_i[AW-1:0];
                  default: ;
               endcase
               if (widx_q == '0 && !mem_rdata_i[OWN_BIT]) begin
                  state_q <= W_IDLE;
               end else if (widx_q == WIDX_END) begin
                  widx_q  <= '0;
                  state_q <= W_DECODE;
               end else begin
                  widx_q  <= widx_q + 1'b1;
                  state_q <= W_FETCH;
               end
            end
            W_DECODE: begin
               rem_q   <= dec_len;
               err_q   <= dec_err;
               state_q <= (dec_len == '0) ? W_WBACK : W_DREQ;
            end
            W_DREQ:  if (acc) state_q <= W_DWAIT;
            W_DWAIT: if (mem_rvalid_i) begin
               word_q  <= mem_rdata_i;
               state_q <= W_STREAM;
            end
            W_STREAM: if (tx_ready_i) begin
               rem_q  <= rem_q - 1'b1;
               bptr_q <= bptr_q + 1'b1;
               if (last_byte)                 state_q <= W_WBACK;
               else if (bptr_q[1:0] == 2'b11) state_q <= W_DREQ;
            end
            W_WBACK: if (acc) begin
               done_q  <= cs_q[LAST_BIT];
               widx_q  <= '0;
               state_q <= W_FETCH;
            end
            default: state_q <= W_IDLE;
         endcase
      end
   end

   assert_stop_on_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_FWAIT && widx_q == '0 && mem_rvalid_i && !mem_rdata_i[OWN_BIT])
      |=> (idle_o && !mem_req_o && !tx_valid_o));
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));
   assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
   assert_done_after_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));
   assert_wb_no_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_addr_o == cur_ptr_o && !mem_wdata_o[OWN_BIT]));
endmodule

// File: tb/txring_walker_tb.sv
`timescale 1ns/1ps
module txring_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        poll_i = 1'b0, base_wr_i = 1'b0;
   logic [31:0] base_i = '0;
   logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
   logic        tx_valid_o, tx_last_o, tx_ready_i = 1'b0;
   logic [7:0]  tx_data_o;
   logic        done_o, err_o, idle_o;
   logic [31:0] cur_ptr_o;

   always #2 clk = ~clk;

   txring_walker u_dut (.*);

   logic [31:0] mem [0:4095];
   logic [8:0]  exp_q[$];
   int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, err_cnt = 0;
   bit pend = 0;
   logic [31:0] pend_d;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input logic [31:0] a);
      return mem[a[13:2]][8*a[1:0] +: 8];
   endfunction

   // memory model and stream monitor; periodic backpressure exercises R12
   always @(negedge clk) begin
      cyc++;
      mem_rvalid_i = pend;
      mem_rdata_i  = pend_d;
      pend = 0;
      mem_ready_i = (cyc % 5) != 3;
      if (rst_n && mem_req_o && mem_ready_i) begin
         if (mem_we_o) mem[mem_addr_o[13:2]] = mem_wdata_o;
         else begin pend = 1; pend_d = mem[mem_addr_o[13:2]]; end
      end
      tx_ready_i = (cyc % 7) != 2;
      if (rst_n && tx_valid_o && tx_ready_i) begin
         if (exp_q.size() == 0) chk(0, "R5 unexpected byte", {24'h0, tx_data_o}, 32'h0);
         else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(tx_data_o == e[7:0], "R5 byte", {24'h0, tx_data_o}, {24'h0, e[7:0]});
            chk(tx_last_o == e[8], "R6 last flag", {31'h0, tx_last_o}, {31'h0, e[8]});
         end
      end
      if (done_o) done_cnt++;
      if (err_o) err_cnt++;
   end

   task automatic put_desc(input logic [31:0] a, input logic [31:0] cs, input logic [15:0] s1,
                           input logic [15:0] s2, input logic [31:0] ba);
      mem[a[13:2]]     = cs;
      mem[a[13:2] + 1] = {s2, s1};
      mem[a[13:2] + 2] = ba;
   endtask

   task automatic expect_bytes(input logic [31:0] ba, input int len, input bit last);
      for (int i = 0; i < len; i++) exp_q.push_back({last && (i == len - 1), mb(ba + 32'(i))});
   endtask

   task automatic run_walk();
      @(negedge clk) poll_i = 1'b1;
      @(negedge clk) poll_i = 1'b0;
      while (!idle_o) @(negedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, "R5 all bytes emitted", exp_q.size(), 0);
   endtask

   task automatic load_base(input logic [31:0] b);
      @(negedge clk) begin base_wr_i = 1'b1; base_i = b; end
      @(negedge clk) base_wr_i = 1'b0;
      chk(cur_ptr_o == b, "R11 base load", cur_ptr_o, b);
   endtask

   localparam logic [31:0] OWN = 32'h8000_0000, LST = 32'h2000_0000, WRP = 32'h0020_0000;

   initial begin
      #(4 * 150000);
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(idle_o && !mem_req_o && !tx_valid_o, "R1 idle quiet", {idle_o, mem_req_o, tx_valid_o}, 3'b100);
      chk(cur_ptr_o == 0, "R1 pointer", cur_ptr_o, 0);
      chk(!done_o && !err_o, "R1 pulses", {done_o, err_o}, 0);
      rst_n = 1'b1;

      // R2 R4 R5 R6: two-segment frame, unaligned start, then a free entry
      load_base(32'h100);
      put_desc(32'h100, OWN | 32'h1234, 16'd5, 16'd0, 32'h401);
      put_desc(32'h120, OWN | LST,      16'd3, 16'd0, 32'h800);
      mem[32'h140 >> 2] = 32'h0;
      expect_bytes(32'h401, 5, 0);
      expect_bytes(32'h800, 3, 1);
      run_walk();
      chk(mem[32'h100 >> 2] == 32'h1234, "R7 writeback own cleared", mem[32'h100 >> 2], 32'h1234);
      chk(mem[32'h120 >> 2] == LST, "R7 writeback keeps flags", mem[32'h120 >> 2], LST);
      chk(mem[32'h104 >> 2] == 32'd5, "R7 word1 untouched", mem[32'h104 >> 2], 5);
      chk(cur_ptr_o == 32'h140, "R8 advance by 32", cur_ptr_o, 32'h140);
      chk(done_cnt == 1, "R9 one done per frame", done_cnt, 1);
      chk(err_cnt == 0, "R10 no error", err_cnt, 0);

      // R8 wrap; R5 masking of size bits above 11 (0xF004 -> 4 bytes, no error)
      put_desc(32'h140, OWN | LST | WRP, 16'hF004, 16'h0000, 32'h903);
      expect_bytes(32'h903, 4, 1);
      run_walk();
      chk(cur_ptr_o == 32'h100, "R8 wrap to base", cur_ptr_o, 32'h100);
      chk(done_cnt == 2, "R9 done count", done_cnt, 2);
      chk(err_cnt == 0, "R10 masked size no error", err_cnt, 0);
      chk(mem[32'h140 >> 2] == (LST | WRP), "R7 wrap writeback", mem[32'h140 >> 2], LST | WRP);

      // R10 size errors still transfer data; R3 stop at free entry
      load_base(32'h200);
      put_desc(32'h200, OWN,       16'd2,    16'd3, 32'hA00);
      put_desc(32'h220, OWN | LST, 16'd2049, 16'd0, 32'h1000);
      mem[32'h240 >> 2] = 32'h0;
      expect_bytes(32'hA00, 5, 0);
      expect_bytes(32'h1000, 2049, 1);
      run_walk();
      chk(err_cnt == 2, "R10 error pulses", err_cnt, 2);
      chk(done_cnt == 3, "R9 done after error frame", done_cnt, 3);
      chk(cur_ptr_o == 32'h240, "R8 pointer after error walk", cur_ptr_o, 32'h240);

      // R13 zero-length last-segment descriptor
      put_desc(32'h240, OWN | LST, 16'd0, 16'd0, 32'h1900);
      mem[32'h260 >> 2] = 32'h0;
      run_walk();
      chk(done_cnt == 4, "R13 done on empty", done_cnt, 4);
      chk(mem[32'h240 >> 2] == LST, "R13 writeback on empty", mem[32'h240 >> 2], LST);
      chk(cur_ptr_o == 32'h260, "R13 pointer moves", cur_ptr_o, 32'h260);

      // R3 poll on a free entry: nothing written, pointer held
      mem[32'h260 >> 2] = 32'h0000_5555;
      run_walk();
      chk(mem[32'h260 >> 2] == 32'h0000_5555, "R3 no writeback", mem[32'h260 >> 2], 32'h5555);
      chk(cur_ptr_o == 32'h260, "R3 pointer held", cur_ptr_o, 32'h260);
      chk(done_cnt == 4 && err_cnt == 2, "R3 no pulses", done_cnt, 4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule